// File: doc/BRIEF.md
# Delayed-Redirect Program Counter Sequencer

This block owns the program counter of a 32-bit fetch stage with one architectural delay slot. Each valid cycle it takes the fetched instruction word, the source-register value and a taken flag from an outside comparator. It classifies the word as a conditional branch, an immediate jump, a register jump or ordinary code. It then computes where control goes next.

A taken transfer does not move the PC at once. The target is latched, the following instruction (the delay slot) is fetched and advances normally, and only after it does the PC load the latched target. The link forms raise a write request for the return address, which skips the slot. A transfer found sitting inside a slot is flagged as illegal and dropped.

Top module: `pc_seq_top`

## Requirements
- R1: While rst_ni is low, pc_o equals the RESET_PC parameter, in_slot_o is 0, and link_we_o and slot_illegal_o are 0.
- R2: When instr_valid_i is 0 the PC and the pending redirect hold unchanged. When it is 1 and no redirect is due, the PC advances by 4.
- R3: An immediate jump (j = opcode 000010, jal = opcode 000011, opcode in bits 31:26) targets {bits 31:28 of PC+4, instruction bits 25:0, 2'b00}. The upper nibble therefore comes from the following address, even when that address crosses a 256 MB region.
- R4: beq (opcode 000100) and bne (opcode 000101) with br_taken_i=1 target PC+4 plus the sign-extended bits 15:0 shifted left by 2. With br_taken_i=0 they fall through to PC+4 with no redirect pending.
- R5: jr (opcode 000000, funct 001000 in bits 5:0) and jalr (opcode 000000, funct 001001) target the full value on rs_val_i.
- R6: A valid jal outside a slot drives link_we_o=1, link_addr_o=31 and link_data_o=PC+8 in the same cycle.
- R7: A valid jalr outside a slot drives link_we_o=1, link_addr_o=instruction bits 15:11 and link_data_o=PC+8. j, branches and other words drive link_we_o=0.
- R8: After a taken transfer the next PC is PC+4 (the slot), in_slot_o is 1 while the slot word is presented, and the valid cycle that consumes the slot loads the target.
- R9: A valid control-flow word presented while in_slot_o=1 drives slot_illegal_o=1 in that cycle. It starts no second redirect and raises no link write, so the PC goes to the first target and then steps by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Fetched word is valid this cycle |
| instr_i | input | 32 | Fetched instruction word at pc_o |
| rs_val_i | input | 32 | Source register value for register jumps |
| br_taken_i | input | 1 | Comparator result for the branch in instr_i |
| pc_o | output | 32 | Address of the instruction being presented |
| in_slot_o | output | 1 | Presented instruction is a delay slot |
| link_we_o | output | 1 | Link register write request |
| link_addr_o | output | 5 | Link destination register |
| link_data_o | output | 32 | Return address (PC+8) |
| slot_illegal_o | output | 1 | Control-flow word found in a delay slot |

## Verification
The bench replays a short loop whose jal, bne, j and jr all have filler words in their slots. It checks the full PC trace. A unit that redirected at once would skip the slot addresses, and one that returned to PC+4 would link to the slot instead of past it. Further cases cover the following:
- a backward branch with a negative offset, where a missing sign extension lands far above the code;
- a jump whose following address has crossed into a new 256 MB region, where splicing from the jump's own address gives the wrong nibble;
- a stall inside the slot, which must neither lose nor fire the redirect early;
- a jal placed in a slot, which must be flagged, must not link and must not redirect a second time.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned IMM26_W = 26;
  localparam int unsigned IMM16_W = 16;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0] OP_J       = 6'b000010;
  localparam logic [OP_W-1:0] OP_JAL     = 6'b000011;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
  localparam logic [OP_W-1:0] FN_JR      = 6'b001000;
  localparam logic [OP_W-1:0] FN_JALR    = 6'b001001;

  typedef enum logic [1:0] {
    CF_NONE   = 2'd0,
    CF_BRANCH = 2'd1,
    CF_JIMM   = 2'd2,
    CF_JREG   = 2'd3
  } cf_class_e;

  typedef struct packed {
    cf_class_e        cls;
    logic             link;
    logic [REG_W-1:0] link_rd;
  } cf_dec_t;
endpackage

// File: rtl/pc_seq_decode.sv
module pc_seq_decode
  import pc_seq_pkg::*;
#(
  parameter logic [REG_W-1:0] LINK_REG = 5'd31
) (
  input  logic [XLEN-1:0] instr_i,
  output cf_dec_t         dec_o
);
  logic [OP_W-1:0] op, fn;
  assign op = instr_i[XLEN-1 -: OP_W];
  assign fn = instr_i[OP_W-1:0];

  always_comb begin
    dec_o.cls     = CF_NONE;
    dec_o.link    = 1'b0;
    dec_o.link_rd = LINK_REG;
    unique case (op)
      OP_BEQ, OP_BNE: dec_o.cls = CF_BRANCH;
      OP_J:           dec_o.cls = CF_JIMM;
      OP_JAL: begin
        dec_o.cls  = CF_JIMM;
        dec_o.link = 1'b1;
      end
      OP_SPECIAL: begin
        if (fn == FN_JR) begin
          dec_o.cls = CF_JREG;
        end else if (fn == FN_JALR) begin
          dec_o.cls     = CF_JREG;
          dec_o.link    = 1'b1;
          dec_o.link_rd = instr_i[15:11];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pc_seq_target.sv
module pc_seq_target
  import pc_seq_pkg::*;
(
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic            br_taken_i,
  input  cf_dec_t         dec_i,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o
);
  localparam int unsigned REGION_W = XLEN - IMM26_W - 2;
  localparam int unsigned SEXT_W   = XLEN - IMM16_W - 2;

  logic [XLEN-1:0] seq_pc, jimm_tgt, br_tgt, br_off;

  assign seq_pc   = pc_i + XLEN'(4);
  // region bits come from the following address, not the jump itself
  assign jimm_tgt = {seq_pc[XLEN-1 -: REGION_W], instr_i[IMM26_W-1:0], 2'b00};
  assign br_off   = {{SEXT_W{instr_i[IMM16_W-1]}}, instr_i[IMM16_W-1:0], 2'b00};
  assign br_tgt   = seq_pc + br_off;

  always_comb begin
    taken_o  = 1'b0;
    target_o = seq_pc;
    unique case (dec_i.cls)
      CF_BRANCH: begin
        taken_o  = br_taken_i;
        target_o = br_tgt;
      end
      CF_JIMM: begin
        taken_o  = 1'b1;
        target_o = jimm_tgt;
      end
      CF_JREG: begin
        taken_o  = 1'b1;
        target_o = rs_val_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pc_seq_link.sv
module pc_seq_link
  import pc_seq_pkg::*;
(
  input  logic             fire_i,
  input  logic [XLEN-1:0]  pc_i,
  input  cf_dec_t          dec_i,
  output logic             we_o,
  output logic [REG_W-1:0] addr_o,
  output logic [XLEN-1:0]  data_o
);
  // return skips the delay slot
  assign we_o   = fire_i & dec_i.link;
  assign addr_o = dec_i.link_rd;
  assign data_o = pc_i + XLEN'(8);
endmodule

// File: rtl/pc_seq_top.sv
module pc_seq_top
  import pc_seq_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000,
  parameter logic [4:0]  LINK_REG = 5'd31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        instr_valid_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs_val_i,
  input  logic        br_taken_i,
  output logic [31:0] pc_o,
  output logic        in_slot_o,
  output logic        link_we_o,
  output logic [4:0]  link_addr_o,
  output logic [31:0] link_data_o,
  output logic        slot_illegal_o
);
  logic [XLEN-1:0] pc_q, tgt_q, tgt_d;
  logic            pend_q, taken, is_cf, start;
  cf_dec_t         dec;

  pc_seq_decode #(.LINK_REG(LINK_REG)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  pc_seq_target u_tgt (
    .pc_i       (pc_q),
    .instr_i    (instr_i),
    .rs_val_i   (rs_val_i),
    .br_taken_i (br_taken_i),
    .dec_i      (dec),
    .taken_o    (taken),
    .target_o   (tgt_d)
  );

  pc_seq_link u_link (
    .fire_i (instr_valid_i & ~pend_q),
    .pc_i   (pc_q),
    .dec_i  (dec),
    .we_o   (link_we_o),
    .addr_o (link_addr_o),
    .data_o (link_data_o)
  );

  assign is_cf = (dec.cls != CF_NONE);
  assign start = instr_valid_i & ~pend_q & taken;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_PC;
      tgt_q  <= RESET_PC;
      pend_q <= 1'b0;
    end else if (instr_valid_i) begin
      if (pend_q) begin
        pc_q   <= tgt_q;
        pend_q <= 1'b0;
      end else begin
        pc_q <= pc_q + XLEN'(4);
        if (start) begin
          tgt_q  <= tgt_d;
          pend_q <= 1'b1;
        end
      end
    end
  end

  assign pc_o           = pc_q;
  assign in_slot_o      = pend_q;
  assign slot_illegal_o = instr_valid_i & pend_q & is_cf;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        instr_valid_i,
  input logic [31:0] instr_i,
  input logic [31:0] pc_o,
  input logic        in_slot_o,
  input logic        link_we_o,
  input logic [4:0]  link_addr_o,
  input logic [31:0] link_data_o,
  input logic        slot_illegal_o
);
  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> ($stable(pc_o) && $stable(in_slot_o)));

  // R8
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !in_slot_o) |=> (pc_o == $past(pc_o) + 32'd4));

  // R8
  slot_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && in_slot_o) |=> !in_slot_o);

  // R6
  jal_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_we_o && instr_i[31:26] == 6'b000011)
      |-> (link_addr_o == 5'd31 && link_data_o == pc_o + 32'd8));

  // R9
  slot_no_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_illegal_o |-> (!link_we_o && in_slot_o));
endmodule

bind pc_seq_top pc_seq_chk u_chk (.*);

// File: tb/pc_seq_top_tb.sv
module pc_seq_top_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC     = 32'h0040_0018;
  localparam logic [31:0] NOP        = 32'h0000_0000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0, br_taken_i = 1'b0;
  logic [31:0] instr_i = NOP, rs_val_i = '0;
  logic [31:0] pc_o, link_data_o;
  logic        in_slot_o, link_we_o, slot_illegal_o;
  logic [4:0]  link_addr_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pc_seq_top #(.RESET_PC(RST_PC)) u_dut (.*);

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [31:0] addr);
    return {op, addr[27:2]};
  endfunction

  function automatic logic [31:0] imem(input logic [31:0] a);
    case (a)
      32'h0040_0018: return 32'h00E0_2020;
      32'h0040_001C: return enc_j(6'b000011, 32'h0040_0024); // jal L2
      32'h0040_0024: return 32'hAE51_0000;
      32'h0040_0028: return 32'h1480_0003;                   // bne -> 0x38
      32'h0040_0030: return enc_j(6'b000010, 32'h0040_0044); // j L1
      32'h0040_0038: return 32'h2084_00A2;
      32'h0040_003C: return enc_j(6'b000010, 32'h0040_0024); // j L2
      32'h0040_0044: return 32'h03E0_0008;                   // jr ra
      default:       return NOP;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] ins, input logic tk, input logic [31:0] rs);
    instr_valid_i = v; instr_i = ins; br_taken_i = tk; rs_val_i = rs;
    #1;
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
    instr_valid_i = 1'b0; instr_i = NOP; br_taken_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; instr_valid_i = 1'b0;
    #1;
    chk(pc_o == RST_PC, "R1 pc", pc_o, RST_PC);
    chk(!in_slot_o && !link_we_o && !slot_illegal_o, "R1 flags",
        {29'd0, in_slot_o, link_we_o, slot_illegal_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_program();
    logic [31:0] trace [17] = '{32'h18, 32'h1C, 32'h20, 32'h24, 32'h28, 32'h2C, 32'h38,
      32'h3C, 32'h40, 32'h24, 32'h28, 32'h2C, 32'h30, 32'h34, 32'h44, 32'h48, 32'h24};
    bit first_bne = 1'b1;
    do_reset();
    chk(enc_j(6'b000011, 32'h0040_0024) == 32'h0C10_0009, "R3 jal encode",
        enc_j(6'b000011, 32'h0040_0024), 32'h0C10_0009);
    for (int i = 0; i < 17; i++) begin
      logic [31:0] exp = 32'h0040_0000 | trace[i];
      logic tk = 1'b0;
      chk(pc_o == exp, "R8 trace", pc_o, exp);
      if (exp == 32'h0040_0028) begin
        tk = first_bne; first_bne = 1'b0;
      end
      drive(1'b1, imem(pc_o), tk, 32'h0040_0024);
      if (exp == 32'h0040_001C)
        chk(link_we_o && link_addr_o == 5'd31 && link_data_o == 32'h0040_0024,
            "R6 jal link", link_data_o, 32'h0040_0024);
      if (exp == 32'h0040_0030 || exp == 32'h0040_0028)
        chk(!link_we_o, "R7 no link", {31'd0, link_we_o}, 32'd0);
      if (exp == 32'h0040_0020)
        chk(in_slot_o, "R8 in slot", {31'd0, in_slot_o}, 32'd1);
      tick();
    end
  endtask

  task automatic t_stall();
    do_reset();
    drive(1'b1, enc_j(6'b000010, 32'h0040_0100), 1'b0, '0);
    chk(!link_we_o, "R7 j no link", {31'd0, link_we_o}, 32'd0);
    tick();
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 32'h0800_0000, 1'b0, '0);
      tick();
      chk(pc_o == 32'h0040_001C && in_slot_o, "R2 stall hold", pc_o, 32'h0040_001C);
    end
    drive(1'b1, NOP, 1'b0, '0); tick();
    chk(pc_o == 32'h0040_0100, "R3 target after slot", pc_o, 32'h0040_0100);
    drive(1'b1, NOP, 1'b0, '0); tick();
    chk(pc_o == 32'h0040_0104, "R2 step", pc_o, 32'h0040_0104);
  endtask

  task automatic t_branch();
    do_reset();
    drive(1'b1, 32'h1000_FFFC, 1'b1, '0); tick(); // beq -4
    chk(pc_o == 32'h0040_001C, "R4 slot pc", pc_o, 32'h0040_001C);
    drive(1'b1, NOP, 1'b0, '0); tick();
    chk(pc_o == 32'h0040_000C, "R4 backward", pc_o, 32'h0040_000C);
    drive(1'b1, 32'h1000_0040, 1'b0, '0); tick(); // beq not taken
    chk(pc_o == 32'h0040_0010 && !in_slot_o, "R4 not taken", pc_o, 32'h0040_0010);
    drive(1'b1, NOP, 1'b0, '0); tick();
    chk(pc_o == 32'h0040_0014, "R4 fall through", pc_o, 32'h0040_0014);
  endtask

  task automatic t_jalr_region();
    do_reset();
    drive(1'b1, 32'h0100_2809, 1'b0, 32'h1FFF_FFFC); // jalr rd=5
    chk(link_we_o && link_addr_o == 5'd5, "R7 jalr rd", {27'd0, link_addr_o}, 32'd5);
    chk(link_data_o == 32'h0040_0020, "R7 jalr data", link_data_o, 32'h0040_0020);
    tick();
    drive(1'b1, NOP, 1'b0, '0); tick();
    chk(pc_o == 32'h1FFF_FFFC, "R5 reg target", pc_o, 32'h1FFF_FFFC);
    drive(1'b1, 32'h0800_0010, 1'b0, '0); tick();
    drive(1'b1, NOP, 1'b0, '0); tick();
    chk(pc_o == 32'h2000_0040, "R3 region splice", pc_o, 32'h2000_0040);
  endtask

  task automatic t_illegal();
    do_reset();
    drive(1'b1, enc_j(6'b000010, 32'h0040_0100), 1'b0, '0); tick();
    drive(1'b1, enc_j(6'b000011, 32'h0040_0200), 1'b0, '0);
    chk(slot_illegal_o, "R9 flag", {31'd0, slot_illegal_o}, 32'd1);
    chk(!link_we_o, "R9 no link", {31'd0, link_we_o}, 32'd0);
    tick();
    chk(pc_o == 32'h0040_0100 && !in_slot_o, "R9 first target", pc_o, 32'h0040_0100);
    chk(!slot_illegal_o, "R9 flag clear", {31'd0, slot_illegal_o}, 32'd0);
    drive(1'b1, NOP, 1'b0, '0); tick();
    chk(pc_o == 32'h0040_0104, "R9 no second redirect", pc_o, 32'h0040_0104);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_program();
    t_stall();
    t_branch();
    t_jalr_region();
    t_illegal();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule